// File: doc/BRIEF.md
# Proxy-Window Message Queue Manager

This block sits between processors on a chip and passes fixed-size messages through hardware queues behind a 32-bit register bus. A producer writes a message one word at a time into a data window that belongs to the target queue. The message is sixteen words long. Writing the last word of the window hands the whole message to the queue. A consumer reads the oldest message through the same window, and reading the last word removes that message. No separate doorbell or pop register is needed.

Every queue takes its message slots from one shared pool, which is kept as linked lists. Each queue also has a depth limit of its own. A second register region reports how many messages each queue holds. One interrupt line per queue stays high while that queue has any message in it. If a commit finds the queue or the pool full, the message is dropped and a sticky overflow output is set.

Top module: `mq_proxy_hub`

## Requirements
- R1: After reset every queue holds zero messages, every `irq` bit is 0, `overflow` is 0, and the staging words of every queue are zero.
- R2: With `bus_state`=0, a data register is addressed as proxy×0x10000 + queue×0x80 + index×4. The proxy field (bits 19:16) does not select different storage: any proxy value reaches the same queue.
- R3: A write to index 31 commits the staged words of that queue (indices 16..30) with the written word as word 15. Words never written since the last commit are committed as zero, and the staging of that queue is cleared after every commit.
- R4: A read of index 16..30 returns that word of the oldest message and leaves the queue unchanged. A read of index 31 returns word 15 and removes the message. Messages come out in commit order.
- R5: Every read returns `rd_data` with `rd_valid`=1 exactly one cycle after the request. With `bus_state`=1, address q×4 reads queue q's message count in bits 23:12, and all other bits read as zero.
- R6: `irq[q]` is 1 exactly while queue q holds at least one message. It drops on the edge that pops the last message.
- R7: A commit to a queue already holding Q_LIMIT messages, or a commit when all POOL_MSGS slots are in use, is dropped, leaves every count unchanged, and sets `overflow`. `overflow` stays set until reset.
- R8: Reading index 31 of an empty queue returns zero and leaves its count at zero.
- R9: The following writes have no effect: writes to indices 0..15, writes to a queue number ≥ NUM_Q, and any write to the state region. Reads of indices 0..15, and reads of a queue or state number ≥ NUM_Q, return zero.
- R10: A slot freed by a pop is available again at once: after the pool has filled, one pop allows exactly one further commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_state | input | 1 | 1 = state region, 0 = data window region |
| bus_addr | input | ADDR_W | Byte address within the selected region |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| irq | output | NUM_Q | Per-queue message-pending interrupt |
| overflow | output | 1 | Sticky dropped-commit flag |

## Verification
The read of index 31 and the removal of the oldest message happen on the same clock edge. That read must return word 15 of the message being removed, while the count and the interrupt change on that edge. To provoke this, the bench reads a message to its end and issues a count read of that queue in the very next cycle. Every read result is compared in order against a scoreboard of expected words. This shows that the popped data belongs to the old message and that the count had already dropped by the following cycle.

// File: rtl/mq_proxy_hub.sv
module mq_proxy_hub #(
  parameter int NUM_Q     = 64,
  parameter int POOL_MSGS = 128,
  parameter int Q_LIMIT   = 128,
  parameter int ADDR_W    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic              bus_state,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic [NUM_Q-1:0]  irq,
  output logic              overflow
);

  localparam int MSG_WORDS = 16;
  localparam int FIRST_REG = 16;
  localparam int LAST_REG  = FIRST_REG + MSG_WORDS - 1;
  localparam int MSG_BITS  = MSG_WORDS * 32;
  localparam int QW        = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int SW        = (POOL_MSGS > 1) ? $clog2(POOL_MSGS) : 1;
  localparam int CW        = $clog2(Q_LIMIT + 1);

  logic [8:0]        q_field;
  logic [4:0]        r_idx;
  logic [ADDR_W-3:0] s_idx;
  logic [QW-1:0]     d_q, s_q;
  logic [3:0]        w_idx;
  logic              q_ok, s_ok, data_hit, is_last, wr_word, commit, pop_req;
  logic              unused_addr_bits;

  assign q_field  = bus_addr[15:7];
  assign r_idx    = bus_addr[6:2];
  assign s_idx    = bus_addr[ADDR_W-1:2];
  assign d_q      = q_field[QW-1:0];
  assign s_q      = s_idx[QW-1:0];
  assign w_idx    = 4'(r_idx - 5'(FIRST_REG));
  assign q_ok     = 32'(q_field) < NUM_Q;
  assign s_ok     = 32'(s_idx) < NUM_Q;
  assign data_hit = bus_en && !bus_state && q_ok && (r_idx >= 5'(FIRST_REG));
  assign is_last  = r_idx == 5'(LAST_REG);
  assign wr_word  = data_hit && bus_wr;
  assign commit   = wr_word && is_last;
  assign pop_req  = data_hit && !bus_wr && is_last;
  assign unused_addr_bits = ^{bus_addr[ADDR_W-1:16], bus_addr[1:0]};

  logic [MSG_BITS-1:0]  stage    [NUM_Q];
  logic [MSG_BITS-1:0]  slot_mem [POOL_MSGS];
  logic [SW-1:0]        nxt      [POOL_MSGS];
  logic [SW-1:0]        head     [NUM_Q];
  logic [SW-1:0]        tail     [NUM_Q];
  logic [CW-1:0]        cnt      [NUM_Q];
  logic [POOL_MSGS-1:0] free_map;

  logic [SW-1:0]       alloc_slot, head_slot;
  logic                have_free, q_has, q_full, commit_ok, pop_ok;
  logic [MSG_BITS-1:0] new_msg;
  logic [31:0]         rd_next;

  always_comb begin
    alloc_slot = '0;
    for (int i = POOL_MSGS - 1; i >= 0; i--)
      if (free_map[i]) alloc_slot = SW'(i);
  end

  assign have_free = |free_map;
  assign head_slot = head[d_q];
  assign q_has     = cnt[d_q] != '0;
  assign q_full    = cnt[d_q] == CW'(Q_LIMIT);
  assign commit_ok = commit && !q_full && have_free;
  assign pop_ok    = pop_req && q_has;

  always_comb begin
    new_msg = stage[d_q];
    new_msg[MSG_BITS-32 +: 32] = bus_wdata;
  end

  always_comb begin
    rd_next = '0;
    if (bus_state) begin
      if (s_ok) rd_next = {8'b0, 12'(cnt[s_q]), 12'b0};
    end else if (data_hit && q_has) begin
      rd_next = slot_mem[head_slot][32*w_idx +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NUM_Q; q++) stage[q] <= '0;
    end else if (commit) begin
      stage[d_q] <= '0;
    end else if (wr_word) begin
      stage[d_q][32*w_idx +: 32] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (commit_ok) begin
      slot_mem[alloc_slot] <= new_msg;
      if (q_has) nxt[tail[d_q]] <= alloc_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_map <= '1;
      overflow <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      for (int q = 0; q < NUM_Q; q++) begin
        head[q] <= '0;
        tail[q] <= '0;
        cnt[q]  <= '0;
      end
    end else begin
      rd_valid <= bus_en && !bus_wr;
      if (bus_en && !bus_wr) rd_data <= rd_next;
      if (commit && !commit_ok) overflow <= 1'b1;
      if (commit_ok) begin
        free_map[alloc_slot] <= 1'b0;
        tail[d_q] <= alloc_slot;
        if (!q_has) head[d_q] <= alloc_slot;
        cnt[d_q] <= cnt[d_q] + 1'b1;
      end
      if (pop_ok) begin
        free_map[head_slot] <= 1'b1;
        head[d_q] <= nxt[head_slot];
        cnt[d_q]  <= cnt[d_q] - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_irq
    assign irq[g] = cnt[g] != '0;
  end

endmodule

// File: rtl/mq_proxy_hub_chk.sv
module mq_proxy_hub_chk #(
  parameter int NUM_Q  = 64,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_wr,
  input logic              bus_state,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic [NUM_Q-1:0]  irq,
  input logic              overflow
);

  always @(negedge clk) begin
    // R1
    if (!rst_n) reset_state_chk: assert (irq == '0 && !overflow);
  end

  // R5
  rdv_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && !bus_wr |=> rd_valid);

  // R5
  rdv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_wr) |=> !rd_valid);

  // R5
  state_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && !bus_wr && bus_state |=> rd_data[31:24] == 8'd0 && rd_data[11:0] == 12'd0);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R6
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> $stable(irq));

  // R6
  irq_nonlast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && (bus_state || bus_addr[6:2] != 5'd31) |=> $stable(irq));

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |=> $countones(irq ^ $past(irq)) <= 1);

endmodule

bind mq_proxy_hub mq_proxy_hub_chk #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
  .bus_state(bus_state), .bus_addr(bus_addr), .rd_valid(rd_valid),
  .rd_data(rd_data), .irq(irq), .overflow(overflow)
);

// File: tb/mq_proxy_hub_tb_top.sv
`timescale 1ns/1ps
module mq_proxy_hub_tb_top;
  localparam int NQ = 4;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0, bus_wr = 1'b0, bus_state = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NQ-1:0] irq;
  logic          overflow;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] exp_v[$];
  string       exp_t[$];

  always #2.5 clk = ~clk;

  mq_proxy_hub #(.NUM_Q(NQ), .POOL_MSGS(6), .Q_LIMIT(4), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_state(bus_state), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq), .overflow(overflow)
  );

  function automatic logic [AW-1:0] da(int p, int q, int r);
    return AW'(p * 'h10000 + q * 'h80 + r * 4);
  endfunction

  function automatic logic [31:0] pat(int q, int tag, int w);
    return {8'(q), 8'(tag), 8'hC3, 8'(w)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(bit wr, bit st, logic [AW-1:0] a, logic [31:0] d);
    bus_en = 1'b1; bus_wr = wr; bus_state = st; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic wr(int p, int q, int r, logic [31:0] d);
    acc(1'b1, 1'b0, da(p, q, r), d);
  endtask

  task automatic rd(int p, int q, int r, logic [31:0] e, string t);
    exp_v.push_back(e); exp_t.push_back(t);
    acc(1'b0, 1'b0, da(p, q, r), '0);
  endtask

  task automatic rds(int q, logic [31:0] e, string t);
    exp_v.push_back(e); exp_t.push_back(t);
    acc(1'b0, 1'b1, AW'(q * 4), '0);
  endtask

  task automatic put_msg(int p, int q, logic [15:0] mask, int tag);
    for (int w = 0; w < 15; w++) if (mask[w]) wr(p, q, 16 + w, pat(q, tag, w));
    wr(p, q, 31, pat(q, tag, 15));
  endtask

  task automatic get_msg(int p, int q, logic [15:0] mask, int tag, string t);
    for (int w = 0; w < 16; w++)
      rd(p, q, 16 + w, (mask[w] || w == 15) ? pat(q, tag, w) : 32'd0, t);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_v.size() == 0) begin
        chk("R5 unexpected read data", rd_data, 32'hFFFF_FFFF);
      end else begin
        automatic logic [31:0] e = exp_v.pop_front();
        automatic string t = exp_t.pop_front();
        chk(t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 irq at reset", 32'(irq), 32'd0);
    chk("R1 overflow at reset", 32'(overflow), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int q = 0; q < NQ; q++) rds(q, 32'd0, "R1 count zero");

    put_msg(0, 1, 16'hFFFF, 'hA1);
    chk("R6 irq after commit", 32'(irq), 32'b0010);
    rds(1, 32'd1 << 12, "R5 count one");
    put_msg(3, 1, 16'h5555, 'hB2);
    rds(1, 32'd2 << 12, "R2 other proxy same queue");

    rd(5, 1, 16, pat(1, 'hA1, 0), "R4 peek word");
    rds(1, 32'd2 << 12, "R4 peek keeps count");
    get_msg(5, 1, 16'hFFFF, 'hA1, "R4 first message");
    rds(1, 32'd1 << 12, "R4 pop then count");
    chk("R6 irq still set", 32'(irq), 32'b0010);
    get_msg(1, 1, 16'h5555, 'hB2, "R3 unwritten words zero");
    chk("R6 irq drops on last pop", 32'(irq), 32'd0);
    rds(1, 32'd0, "R4 queue empty");

    rd(0, 1, 31, 32'd0, "R8 pop empty data");
    rds(1, 32'd0, "R8 pop empty count");

    wr(0, 0, 5, 32'hDEAD_BEEF);
    acc(1'b1, 1'b1, AW'(0), 32'hFFFF_FFFF);
    wr(0, 5, 31, 32'h1234_5678);
    chk("R9 ignored writes irq", 32'(irq), 32'd0);
    rds(0, 32'd0, "R9 state unchanged");
    rds(6, 32'd0, "R9 state beyond queues");

    wr(0, 2, 16, 32'h0000_1234);
    wr(0, 2, 31, 32'h0000_0011);
    wr(0, 2, 31, 32'h0000_0022);
    rds(2, 32'd2 << 12, "R3 two commits");
    rd(0, 2, 16, 32'h0000_1234, "R3 staged word");
    rd(0, 2, 31, 32'h0000_0011, "R3 commit word");
    rd(0, 2, 16, 32'd0, "R3 staging cleared");

    for (int i = 0; i < 4; i++) wr(0, 0, 31, 32'(100 + i));
    rds(0, 32'd4 << 12, "R7 queue at limit");
    chk("R7 no overflow yet", 32'(overflow), 32'd0);
    wr(0, 0, 31, 32'd104);
    chk("R7 queue full overflow", 32'(overflow), 32'd1);
    rds(0, 32'd4 << 12, "R7 count kept");
    wr(0, 3, 31, 32'h77);
    wr(0, 3, 31, 32'h78);
    rds(3, 32'd1 << 12, "R7 pool full drop");
    rd(0, 0, 3, 32'd0, "R9 low register read");

    rd(0, 2, 31, 32'h22, "R10 pop frees slot");
    wr(0, 3, 31, 32'h79);
    rds(3, 32'd2 << 12, "R10 reuse slot");
    rd(0, 3, 31, 32'h77, "R10 order");
    rd(0, 3, 31, 32'h79, "R10 order");

    for (int i = 0; i < 4; i++) rd(0, 0, 31, 32'(100 + i), "R4 fifo order");
    rds(0, 32'd0, "R4 drained");
    chk("R6 all idle", 32'(irq), 32'd0);
    chk("R7 overflow sticky", 32'(overflow), 32'd1);

    repeat (3) @(negedge clk);
    chk("R5 every read answered", 32'(exp_v.size()), 32'd0);
    finish_run();
  end
endmodule